// File: doc/BRIEF.md
# Descriptor Ring Transmit/Receive Engine

This block moves frames between a word-addressed synchronous memory and two byte streams by walking two circular rings of buffer descriptors, one per direction. A descriptor occupies two consecutive memory words. The first word carries a 16-bit status halfword in bits [31:16] and a 16-bit length in bits [15:0]. The second word carries the word address of the frame buffer. In a buffer, every word holds one frame byte in bits [7:0]. Software builds the rings, marks descriptors as owned by the engine, and the engine hands each one back by rewriting its status word.

The transmit side fetches the descriptor at its current position. When the descriptor is marked ready, it streams the buffer out as bytes, honours the last-in-frame, append-CRC and interrupt-request flags, and then clears ready. It halts when it finds a descriptor that is not ready. The receive side accepts a byte stream into descriptors marked empty, records length and error status, and halts with a busy event when the ring is full. Each direction has a clear-halt pulse and a graceful-stop level. Five sticky event bits, each with an enable, drive a single interrupt line.

Top module: `dring_engine`

## Requirements
- R1: A descriptor is two words: status in [31:16] and length in [15:0] of the word at ring base plus current offset, and the buffer word address in the next word. The offset starts at zero, steps by two words, and returns to zero after a descriptor whose status bit 13 (wrap) is set. Base and offset are added at each access.
- R2: A transmit descriptor is used only while status bit 15 (ready) is set. Finding it clear halts the transmitter with no byte output. A tx_clr_halt pulse makes it poll the same descriptor again.
- R3: For a ready descriptor, exactly length bytes are output on tx_data, taken from bits [7:0] of consecutive words starting at the buffer address. tx_last marks the final byte only when status bit 11 is set. tx_crc marks the final byte only when status bit 10 is set.
- R4: After its final byte, the transmit descriptor's status word is rewritten with ready cleared and all other status bits and the length unchanged. Event bit 0 is raised only when status bit 12 (interrupt request) is set.
- R5: The receiver fills only a descriptor with status bit 15 (empty) set. It writes each accepted byte to consecutive buffer words, then rewrites the status word with empty cleared, wrap kept, and length equal to the bytes stored. It then raises event bit 1.
- R6: Bytes beyond rx_max_len are not stored. The length is then rx_max_len and status bit 5 is set. rx_err on any byte of the frame sets status bit 2.
- R7: When the receiver fetches a descriptor whose empty bit is clear, it raises event bit 2, drops rx_ready and stays halted until an rx_clr_halt pulse.
- R8: While tx_stop is high, the transmitter finishes the frame in progress through the descriptor carrying the last flag. It starts no further descriptor and raises event bit 3. A halted transmitter stops at once.
- R9: While rx_stop is high, the receiver finishes a frame that has started. An idle receiver, whether halted or waiting for a first byte, stops at once. Either way it raises event bit 4 and holds rx_ready low.
- R10: Event bits stay set until a one is written to the matching ev_clr bit. irq is high exactly when some event is set whose ev_en bit is set.
- R11: After reset all events and irq are low, tx_valid and rx_ready are low, and both directions are halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_base | input | AW | Transmit ring base word address |
| rx_base | input | AW | Receive ring base word address |
| rx_max_len | input | 16 | Largest number of bytes stored per receive frame |
| tx_clr_halt | input | 1 | Pulse: resume transmit ring polling |
| rx_clr_halt | input | 1 | Pulse: resume receive ring filling |
| tx_stop | input | 1 | Graceful transmit stop request (level) |
| rx_stop | input | 1 | Graceful receive stop request (level) |
| ev_clr | input | 5 | Write-one-to-clear for event bits |
| ev_en | input | 5 | Per-event interrupt enable |
| events | output | 5 | Pending events: 0 tx done, 1 rx done, 2 rx busy, 3 tx stopped, 4 rx stopped |
| irq | output | 1 | Interrupt request |
| txm_en | output | 1 | Transmit memory port access strobe |
| txm_we | output | 1 | Transmit memory port write enable |
| txm_addr | output | AW | Transmit memory port word address |
| txm_wdata | output | 32 | Transmit memory port write data |
| txm_rdata | input | 32 | Transmit memory port read data, valid the cycle after a read |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_crc | output | 1 | Append CRC after this final byte |
| rxm_en | output | 1 | Receive memory port access strobe |
| rxm_we | output | 1 | Receive memory port write enable |
| rxm_addr | output | AW | Receive memory port word address |
| rxm_wdata | output | 32 | Receive memory port write data |
| rxm_rdata | input | 32 | Receive memory port read data, valid the cycle after a read |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the received frame |
| rx_err | input | 1 | Byte belongs to a bad frame |
| rx_ready | output | 1 | Receiver accepts a byte this cycle |

## Verification
The first transmit byte appears five clock edges after the tx_clr_halt edge: fetch, status wait, pointer read, pointer wait, and byte read. Each further byte follows two edges later. The descriptor write-back is issued one edge after the final byte, and the event bit is visible one edge after that. A received byte reaches memory at the same edge that accepts it. Its descriptor is rewritten one edge after the byte flagged last, and the event follows one edge later. The bench compares every transmitted byte, with its last and CRC marks, against an expected list on each falling edge. It inspects memory words, events, irq and rx_ready only after windows well past these latencies.

// File: rtl/dring_pkg.sv
package dring_pkg;
    localparam int WORD_W = 32;
    localparam int ST_W   = 16;
    localparam int LEN_W  = 16;
    localparam int ST_LSB = 16;

    // transmit status bits
    localparam int TXB_READY = 15;
    localparam int TXB_WRAP  = 13;
    localparam int TXB_INTR  = 12;
    localparam int TXB_LAST  = 11;
    localparam int TXB_CRC   = 10;

    // receive status bits
    localparam int RXB_EMPTY = 15;
    localparam int RXB_WRAP  = 13;
    localparam int RXB_TRUNC = 5;
    localparam int RXB_BAD   = 2;

    // event vector positions
    localparam int EV_TXF   = 0;
    localparam int EV_RXF   = 1;
    localparam int EV_BSY   = 2;
    localparam int EV_TSTOP = 3;
    localparam int EV_RSTOP = 4;
    localparam int EV_N     = 5;

    typedef enum logic [3:0] {
        TX_HALT, TX_FETCH, TX_FWAIT, TX_PTR, TX_PWAIT,
        TX_BYTE, TX_BWAIT, TX_WB, TX_STOP
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_HALT, RX_FETCH, RX_FWAIT, RX_PTR, RX_PWAIT,
        RX_RECV, RX_WB, RX_STOP
    } rx_st_e;
endpackage

// File: rtl/dring_tx.sv
module dring_tx import dring_pkg::*; #(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     base,
    input  logic              clr_halt,
    input  logic              grace,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_crc,
    output logic              ev_done,
    output logic              ev_stop
);
    typedef struct packed {
        tx_st_e           st;
        logic [AW-1:0]    off;
        logic [ST_W-1:0]  stat;
        logic [LEN_W-1:0] len;
        logic [AW-1:0]    ptr;
        logic [LEN_W-1:0] cnt;
    } tx_s_t;

    tx_s_t         q, d;
    logic [AW-1:0] desc_a;
    logic          fin;
    logic [ST_W-1:0] rd_st;

    assign desc_a  = base + q.off;
    assign fin     = (q.cnt == q.len - 1'b1);
    assign rd_st   = mem_rdata[ST_LSB +: ST_W];
    assign tx_data = mem_rdata[7:0];

    always_comb begin
        d         = q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        tx_crc    = 1'b0;
        ev_done   = 1'b0;
        ev_stop   = 1'b0;
        case (q.st)
            TX_HALT: begin
                if (grace) begin
                    d.st    = TX_STOP;
                    ev_stop = 1'b1;
                end else if (clr_halt) begin
                    d.st = TX_FETCH;
                end
            end
            TX_FETCH: begin
                mem_en   = 1'b1;
                mem_addr = desc_a;
                d.st     = TX_FWAIT;
            end
            TX_FWAIT: begin
                d.stat = rd_st;
                d.len  = mem_rdata[LEN_W-1:0];
                d.st   = rd_st[TXB_READY] ? TX_PTR : TX_HALT;
            end
            TX_PTR: begin
                mem_en   = 1'b1;
                mem_addr = desc_a + AW'(1);
                d.st     = TX_PWAIT;
            end
            TX_PWAIT: begin
                d.ptr = mem_rdata[AW-1:0];
                d.cnt = '0;
                d.st  = (q.len == '0) ? TX_WB : TX_BYTE;
            end
            TX_BYTE: begin
                mem_en   = 1'b1;
                mem_addr = q.ptr + q.cnt[AW-1:0];
                d.st     = TX_BWAIT;
            end
            TX_BWAIT: begin
                tx_valid = 1'b1;
                tx_last  = fin & q.stat[TXB_LAST];
                tx_crc   = fin & q.stat[TXB_CRC];
                d.cnt    = q.cnt + 1'b1;
                d.st     = fin ? TX_WB : TX_BYTE;
            end
            TX_WB: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_a;
                mem_wdata = {q.stat & ~(ST_W'(1) << TXB_READY), q.len};
                ev_done   = q.stat[TXB_INTR];
                d.off     = q.stat[TXB_WRAP] ? '0 : q.off + AW'(2);
                if (grace && q.stat[TXB_LAST]) begin
                    d.st    = TX_STOP;
                    ev_stop = 1'b1;
                end else begin
                    d.st = TX_FETCH;
                end
            end
            TX_STOP: begin
                if (!grace) d.st = TX_HALT;
            end
            default: d.st = TX_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dring_rx.sv
module dring_rx import dring_pkg::*; #(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     base,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              clr_halt,
    input  logic              grace,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    output logic              rx_ready,
    output logic              ev_done,
    output logic              ev_busy,
    output logic              ev_stop
);
    typedef struct packed {
        rx_st_e           st;
        logic [AW-1:0]    off;
        logic [ST_W-1:0]  stat;
        logic [AW-1:0]    ptr;
        logic [LEN_W-1:0] cnt;
        logic             trunc;
        logic             bad;
        logic             started;
    } rx_s_t;

    rx_s_t           q, d;
    logic [AW-1:0]   desc_a;
    logic [ST_W-1:0] rd_st;
    logic [ST_W-1:0] wb_st;

    assign desc_a = base + q.off;
    assign rd_st  = mem_rdata[ST_LSB +: ST_W];

    always_comb begin
        wb_st            = q.stat;
        wb_st[RXB_EMPTY] = 1'b0;
        wb_st[RXB_TRUNC] = q.trunc;
        wb_st[RXB_BAD]   = q.bad;
    end

    always_comb begin
        d         = q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        ev_done   = 1'b0;
        ev_busy   = 1'b0;
        ev_stop   = 1'b0;
        case (q.st)
            RX_HALT: begin
                if (grace) begin
                    d.st    = RX_STOP;
                    ev_stop = 1'b1;
                end else if (clr_halt) begin
                    d.st = RX_FETCH;
                end
            end
            RX_FETCH: begin
                mem_en   = 1'b1;
                mem_addr = desc_a;
                d.st     = RX_FWAIT;
            end
            RX_FWAIT: begin
                d.stat = rd_st;
                if (rd_st[RXB_EMPTY]) begin
                    d.st = RX_PTR;
                end else begin
                    d.st    = RX_HALT;
                    ev_busy = 1'b1;
                end
            end
            RX_PTR: begin
                mem_en   = 1'b1;
                mem_addr = desc_a + AW'(1);
                d.st     = RX_PWAIT;
            end
            RX_PWAIT: begin
                d.ptr     = mem_rdata[AW-1:0];
                d.cnt     = '0;
                d.trunc   = 1'b0;
                d.bad     = 1'b0;
                d.started = 1'b0;
                d.st      = RX_RECV;
            end
            RX_RECV: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.started = 1'b1;
                    d.bad     = q.bad | rx_err;
                    if (q.cnt < max_len) begin
                        mem_en    = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = q.ptr + q.cnt[AW-1:0];
                        mem_wdata = {{(WORD_W-8){1'b0}}, rx_data};
                        d.cnt     = q.cnt + 1'b1;
                    end else begin
                        d.trunc = 1'b1;
                    end
                    if (rx_last) d.st = RX_WB;
                end else if (grace && !q.started) begin
                    d.st    = RX_STOP;
                    ev_stop = 1'b1;
                end
            end
            RX_WB: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_a;
                mem_wdata = {wb_st, q.cnt};
                ev_done   = 1'b1;
                d.off     = q.stat[RXB_WRAP] ? '0 : q.off + AW'(2);
                if (grace) begin
                    d.st    = RX_STOP;
                    ev_stop = 1'b1;
                end else begin
                    d.st = RX_FETCH;
                end
            end
            RX_STOP: begin
                if (!grace) d.st = RX_HALT;
            end
            default: d.st = RX_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dring_events.sv
module dring_events #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] pending,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] ev;
    } ev_s_t;

    ev_s_t q, d;

    always_comb begin
        d.ev = (q.ev & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = q.ev;
    assign irq     = |(q.ev & en);
endmodule

// File: rtl/dring_engine.sv
module dring_engine import dring_pkg::*; #(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     tx_base,
    input  logic [AW-1:0]     rx_base,
    input  logic [LEN_W-1:0]  rx_max_len,
    input  logic              tx_clr_halt,
    input  logic              rx_clr_halt,
    input  logic              tx_stop,
    input  logic              rx_stop,
    input  logic [EV_N-1:0]   ev_clr,
    input  logic [EV_N-1:0]   ev_en,
    output logic [EV_N-1:0]   events,
    output logic              irq,
    output logic              txm_en,
    output logic              txm_we,
    output logic [AW-1:0]     txm_addr,
    output logic [WORD_W-1:0] txm_wdata,
    input  logic [WORD_W-1:0] txm_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_crc,
    output logic              rxm_en,
    output logic              rxm_we,
    output logic [AW-1:0]     rxm_addr,
    output logic [WORD_W-1:0] rxm_wdata,
    input  logic [WORD_W-1:0] rxm_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    output logic              rx_ready
);
    logic tx_done, tx_stopped, rx_done, rx_busy, rx_stopped;
    logic [EV_N-1:0] ev_set;

    dring_tx #(.AW(AW)) u_tx (
        .clk(clk), .rst_n(rst_n), .base(tx_base), .clr_halt(tx_clr_halt),
        .grace(tx_stop), .mem_en(txm_en), .mem_we(txm_we), .mem_addr(txm_addr),
        .mem_wdata(txm_wdata), .mem_rdata(txm_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_crc(tx_crc),
        .ev_done(tx_done), .ev_stop(tx_stopped)
    );

    dring_rx #(.AW(AW)) u_rx (
        .clk(clk), .rst_n(rst_n), .base(rx_base), .max_len(rx_max_len),
        .clr_halt(rx_clr_halt), .grace(rx_stop), .mem_en(rxm_en), .mem_we(rxm_we),
        .mem_addr(rxm_addr), .mem_wdata(rxm_wdata), .mem_rdata(rxm_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_ready(rx_ready), .ev_done(rx_done), .ev_busy(rx_busy), .ev_stop(rx_stopped)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[EV_TXF]   = tx_done;
        ev_set[EV_RXF]   = rx_done;
        ev_set[EV_BSY]   = rx_busy;
        ev_set[EV_TSTOP] = tx_stopped;
        ev_set[EV_RSTOP] = rx_stopped;
    end

    dring_events #(.N(EV_N)) u_ev (
        .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr), .en(ev_en),
        .pending(events), .irq(irq)
    );
endmodule

// File: rtl/dring_engine_chk.sv
module dring_engine_chk import dring_pkg::*; #(
    parameter int AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EV_N-1:0]   events,
    input logic [EV_N-1:0]   ev_clr,
    input logic [EV_N-1:0]   ev_en,
    input logic              irq,
    input logic              txm_en,
    input logic              txm_we,
    input logic [WORD_W-1:0] txm_wdata,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              tx_crc,
    input logic              rx_ready
);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(events) & ~events) & ~$past(ev_clr)) == '0));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((events & ev_en) == '0) |-> !irq);

    assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_crc_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_crc |-> tx_valid);

    assert_wb_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txm_we |-> (txm_en && !txm_wdata[ST_LSB + TXB_READY]));

    assert_busy_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(events[EV_BSY]) |-> !rx_ready);

    assert_tstop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(events[EV_TSTOP]) |-> !tx_valid);

    assert_rstop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(events[EV_RSTOP]) |-> !rx_ready);
endmodule

bind dring_engine dring_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .events(events), .ev_clr(ev_clr), .ev_en(ev_en),
    .irq(irq), .txm_en(txm_en), .txm_we(txm_we), .txm_wdata(txm_wdata),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_crc(tx_crc), .rx_ready(rx_ready)
);

// File: tb/tb_dring_engine.sv
module tb_dring_engine;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tx_base = '0, rx_base = '0;
    logic [15:0] rx_max_len = 16'd4;
    logic        tx_clr_halt = 0, rx_clr_halt = 0, tx_stop = 0, rx_stop = 0;
    logic [4:0]  ev_clr = '0, ev_en = '0;
    logic [4:0]  events;
    logic        irq;
    logic        txm_en, txm_we, rxm_en, rxm_we;
    logic [7:0]  txm_addr, rxm_addr;
    logic [31:0] txm_wdata, rxm_wdata, txm_rdata, rxm_rdata;
    logic        tx_valid, tx_last, tx_crc, rx_ready;
    logic [7:0]  tx_data;
    logic        rx_valid = 0, rx_last = 0, rx_err = 0;
    logic [7:0]  rx_data = '0;

    logic        sw_we = 0;
    logic [7:0]  sw_a = '0;
    logic [31:0] sw_d = '0;
    logic [31:0] mem [256];

    int n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;
    logic [9:0] exp_mem [64];
    int exp_wr = 0, exp_rd = 0;

    always #10 clk = ~clk;

    dring_engine #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .tx_base(tx_base), .rx_base(rx_base),
        .rx_max_len(rx_max_len), .tx_clr_halt(tx_clr_halt), .rx_clr_halt(rx_clr_halt),
        .tx_stop(tx_stop), .rx_stop(rx_stop), .ev_clr(ev_clr), .ev_en(ev_en),
        .events(events), .irq(irq), .txm_en(txm_en), .txm_we(txm_we),
        .txm_addr(txm_addr), .txm_wdata(txm_wdata), .txm_rdata(txm_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_crc(tx_crc),
        .rxm_en(rxm_en), .rxm_we(rxm_we), .rxm_addr(rxm_addr), .rxm_wdata(rxm_wdata),
        .rxm_rdata(rxm_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_err(rx_err), .rx_ready(rx_ready)
    );

    // synchronous memory: software port plus one port per direction
    always @(posedge clk) begin
        if (sw_we) mem[sw_a] <= sw_d;
        if (txm_en) begin
            if (txm_we) mem[txm_addr] <= txm_wdata;
            else        txm_rdata <= mem[txm_addr];
        end
        if (rxm_en) begin
            if (rxm_we) mem[rxm_addr] <= rxm_wdata;
            else        rxm_rdata <= mem[rxm_addr];
        end
    end

    // expected transmit stream, compared on every falling edge
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            mon_chk++;
            if (exp_rd >= exp_wr) begin
                mon_err++;
                $display("FAIL R3: unexpected byte actual %h expected none", tx_data);
            end else begin
                if ({tx_last, tx_crc, tx_data} !== exp_mem[exp_rd]) begin
                    mon_err++;
                    $display("FAIL R3: tx {last,crc,data} actual %h expected %h",
                             {tx_last, tx_crc, tx_data}, exp_mem[exp_rd]);
                end
                exp_rd++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk + mon_chk + 1, n_err + mon_err + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dv);
        sw_we = 1; sw_a = a; sw_d = dv;
        @(negedge clk);
        sw_we = 0;
    endtask

    // load a transmit descriptor and its data; optionally expect its bytes
    task automatic tx_load(input logic [7:0] a, input logic [15:0] st, input int len,
                           input logic [7:0] ptr, input logic [7:0] b0, input bit push);
        wr(a, {st, 16'(len)});
        wr(a + 8'd1, {24'd0, ptr});
        for (int i = 0; i < len; i++) wr(ptr + 8'(i), {24'd0, b0 + 8'(i)});
        if (push) tx_push(st, len, b0);
    endtask

    task automatic tx_push(input logic [15:0] st, input int len, input logic [7:0] b0);
        for (int i = 0; i < len; i++) begin
            exp_mem[exp_wr] = {st[11] && (i == len - 1), st[10] && (i == len - 1), b0 + 8'(i)};
            exp_wr++;
        end
    endtask

    task automatic pulse_tx;
        tx_clr_halt = 1; @(negedge clk); tx_clr_halt = 0;
    endtask

    task automatic pulse_rx;
        rx_clr_halt = 1; @(negedge clk); rx_clr_halt = 0;
    endtask

    task automatic clr_ev(input logic [4:0] m);
        ev_clr = m; @(negedge clk); ev_clr = '0;
    endtask

    task automatic send_byte(input logic [7:0] dv, input bit last, input bit err);
        rx_valid = 1; rx_data = dv; rx_last = last; rx_err = err;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 0; rx_last = 0; rx_err = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk("R11 events", 32'(events), 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 tx_valid", 32'(tx_valid), 0);
        chk("R11 rx_ready", 32'(rx_ready), 0);
        idle(5);
        chk("R11 tx halted, no byte", 32'(exp_rd), 0);

        // transmit ring of two at 0x10
        tx_base = 8'h10;
        tx_load(8'h10, 16'h9C00, 3, 8'h40, 8'hA0, 1);
        tx_load(8'h12, 16'hA800, 2, 8'h50, 8'hB0, 1);
        pulse_tx();
        idle(60);
        chk("R3 all bytes sent", 32'(exp_rd), 32'(exp_wr));
        chk("R4 desc0 written back", mem[8'h10], {16'h1C00, 16'd3});
        chk("R4 desc1 written back", mem[8'h12], {16'h2800, 16'd2});
        chk("R4 tx event", 32'(events), 32'h01);
        chk("R10 irq disabled", 32'(irq), 0);
        ev_en = 5'h01;
        @(negedge clk);
        chk("R10 irq enabled", 32'(irq), 1);
        clr_ev(5'h01);
        chk("R10 event cleared", 32'(events), 0);
        chk("R10 irq after clear", 32'(irq), 0);

        // ring empty: clear-halt polls, nothing goes out
        pulse_tx();
        idle(20);
        chk("R2 no byte when not ready", 32'(exp_rd), 32'(exp_wr));
        chk("R2 desc untouched", mem[8'h10], {16'h1C00, 16'd3});
        chk("R2 no event", 32'(events), 0);

        // re-arm: ring restarts at base after wrap
        tx_load(8'h10, 16'h9C00, 3, 8'h40, 8'hA0, 1);
        tx_load(8'h12, 16'hA800, 2, 8'h50, 8'hB0, 1);
        pulse_tx();
        idle(60);
        chk("R1 wrap resend", 32'(exp_rd), 32'(exp_wr));
        chk("R1 desc0 again", mem[8'h10], {16'h1C00, 16'd3});
        clr_ev(5'h01);

        // graceful transmit stop across a two-descriptor frame
        tx_base = 8'h20;
        tx_load(8'h20, 16'h8000, 2, 8'h60, 8'hC0, 1);
        tx_load(8'h22, 16'h8800, 1, 8'h64, 8'hC4, 1);
        tx_load(8'h24, 16'hA800, 1, 8'h68, 8'hC8, 0);
        pulse_tx();
        tx_stop = 1;
        idle(60);
        chk("R8 frame finished", 32'(exp_rd), 32'(exp_wr));
        chk("R8 stop event", 32'(events), 32'h08);
        chk("R8 next desc untouched", mem[8'h24], {16'hA800, 16'd1});
        tx_stop = 0;
        @(negedge clk);
        clr_ev(5'h08);
        tx_push(16'hA800, 1, 8'hC8);
        pulse_tx();
        idle(30);
        chk("R8 resume sends next", 32'(exp_rd), 32'(exp_wr));
        chk("R4 no event without intr flag", 32'(events), 0);
        chk("R4 desc C written back", mem[8'h24], {16'h2800, 16'd1});

        // receive ring of three at 0x80
        rx_base = 8'h80;
        wr(8'h80, 32'h8000_0000); wr(8'h81, 32'hA0);
        wr(8'h82, 32'h8000_0000); wr(8'h83, 32'hB0);
        wr(8'h84, 32'hA000_0000); wr(8'h85, 32'hC0);
        wr(8'hB4, 32'hDEAD);
        pulse_rx();
        idle(10);
        send_byte(8'h11, 0, 0); send_byte(8'h12, 0, 0); send_byte(8'h13, 1, 0);
        idle(10);
        chk("R5 byte0", mem[8'hA0], 32'h11);
        chk("R5 byte2", mem[8'hA2], 32'h13);
        chk("R5 status", mem[8'h80], {16'h0000, 16'd3});
        chk("R5 rx event", 32'(events), 32'h02);
        clr_ev(5'h02);

        send_byte(8'h21, 0, 0); send_byte(8'h22, 0, 1); send_byte(8'h23, 0, 0);
        send_byte(8'h24, 0, 0); send_byte(8'h25, 0, 0); send_byte(8'h26, 1, 0);
        idle(10);
        chk("R6 stored up to max", mem[8'hB3], 32'h24);
        chk("R6 beyond max not stored", mem[8'hB4], 32'hDEAD);
        chk("R6 trunc and bad", mem[8'h82], {16'h0024, 16'd4});

        send_byte(8'h31, 0, 0); send_byte(8'h32, 1, 0);
        idle(10);
        chk("R5 wrap kept", mem[8'h84], {16'h2000, 16'd2});
        chk("R7 busy event", 32'(events), 32'h06);
        chk("R7 rx_ready low", 32'(rx_ready), 0);
        idle(10);
        chk("R7 still halted", 32'(rx_ready), 0);

        wr(8'h80, 32'h8000_0000);
        clr_ev(5'h06);
        pulse_rx();
        send_byte(8'h41, 1, 0);
        idle(10);
        chk("R1 rx wrap to base", mem[8'hA0], 32'h41);
        chk("R1 rx desc status", mem[8'h80], {16'h0000, 16'd1});
        chk("R7 busy at filled desc", 32'(events[2]), 1);

        // graceful receive stop: idle then mid-frame
        wr(8'h82, 32'h8000_0000);
        clr_ev(5'h06);
        rx_stop = 1;
        idle(3);
        chk("R9 idle stop event", 32'(events), 32'h10);
        chk("R9 rx_ready low", 32'(rx_ready), 0);
        rx_stop = 0;
        @(negedge clk);
        clr_ev(5'h10);
        pulse_rx();
        send_byte(8'h51, 0, 0);
        rx_stop = 1;
        send_byte(8'h52, 0, 0);
        send_byte(8'h53, 1, 0);
        idle(10);
        chk("R9 frame completed", mem[8'h82], {16'h0000, 16'd3});
        chk("R9 stop after frame", 32'(events), 32'h12);
        chk("R9 rx_ready low after stop", 32'(rx_ready), 0);

        chk("R3 no leftover bytes", 32'(exp_rd), 32'(exp_wr));
        $display("Simulation finished: %0d checks, %0d errors", n_chk + mon_chk, n_err + mon_err);
        $finish;
    end
endmodule